// File: doc/BRIEF.md
# Dual-Identity Two-Wire Bus Slave

This block is the slave side of a two-wire serial bus (I2C-style). One instance answers to two 4-bit device identifiers, so software on the bus sees two separate devices. Identifier `1010` steers a transaction to a memory back end. Identifier `1101` steers it to a clock/companion register back end. Any other identifier is left unanswered. SCL and SDA are oversampled by the system clock through two-flop synchronizers, and Start and Stop are found from edges of the synchronized lines. The only pin the block drives toward the bus is an open-drain enable that pulls SDA low.

The address byte is sent MSB first and has three fields. Bits 7:4 hold the identifier, bits 3:1 hold three select bits, and bit 0 is the direction (1 = read). The select bits are held on `dev_sel_o` for whichever back end was addressed.

Write data leaves on a valid/ready port, one per back end. At the end of a received data byte, the addressed port's ready is sampled once. If ready is high, valid is raised for exactly one cycle with the byte on `wr_data_o`, and the byte is acknowledged. If ready is low, no valid is raised, the byte is dropped, and the slave withholds ACK, which ends the operation. The bus is never stretched, so back-pressure turns into a NACK rather than a stall.

Reads use a one-cycle request strobe. The back end must present the byte on its read-data input during the next cycle, and it has no ready.

Top module: `dual_id_bus_slave`

## Requirements
- R1: An address byte whose bits 7:4 are `1010` is acknowledged, and its data traffic appears only on the memory port (`mem_*`).
- R2: An address byte whose bits 7:4 are `1101` is acknowledged and routed only to the companion port (`rtc_*`). Any other identifier gets no ACK and raises no strobe on either port.
- R3: A Start (SDA falling while SCL is high) at any point abandons the transfer in progress, including a partial byte. The next 8 bits are then taken as a fresh address byte.
- R4: A Stop (SDA rising while SCL is high) ends the operation. A partially received byte is discarded and produces no write strobe.
- R5: Address bits are taken MSB first. Bits 3:1 appear on `dev_sel_o` once the address is accepted, and bit 0 = 1 selects a read while 0 selects a write.
- R6: In a write, after the 8th data bit the addressed port's `wr_ready` is sampled. If it is 1, `wr_valid` pulses for one cycle with the byte and the slave pulls SDA low in the ACK slot. If it is 0, there is no pulse, no ACK, and later bytes are ignored until the next Start.
- R7: In a read, the slave raises `rd_req` for one cycle, takes the byte presented in the next cycle, and drives it MSB first. It repeats this for each byte the master ACKs. After a master NACK it releases SDA and issues no further request.
- R8: While `pwr_fail_i` is 1, any transaction is aborted and Starts are ignored. After it clears, nothing is acknowledged until a new Start has been seen.
- R9: The SDA pull enable changes only while the synchronized SCL is low, except when it is released because of a power failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| pwr_fail_i | input | 1 | Power-fail indication; aborts and blocks traffic |
| dev_sel_o | output | 3 | Select bits 3:1 of the last accepted address |
| wr_data_o | output | 8 | Write byte, valid with either port's `wr_valid` |
| mem_wr_valid_o | output | 1 | Memory port write valid (one-cycle) |
| mem_wr_ready_i | input | 1 | Memory port can take a byte |
| mem_rd_req_o | output | 1 | Memory port read request strobe |
| mem_rd_data_i | input | 8 | Memory read byte, valid the cycle after request |
| rtc_wr_valid_o | output | 1 | Companion port write valid (one-cycle) |
| rtc_wr_ready_i | input | 1 | Companion port can take a byte |
| rtc_rd_req_o | output | 1 | Companion port read request strobe |
| rtc_rd_data_i | input | 8 | Companion read byte, valid the cycle after request |

## Verification
The main function is driven with a table of complete write transactions. The table mixes the two accepted identifiers, several rejected identifiers and different select values, and it holds the back-end ready both high and low. The ACK seen on the bus, the port that receives the strobe and the byte it carries are enough to tell correct steering apart from mis-steering, from false acceptance and from ignored back-pressure. Multi-byte reads from each back end check both the byte order and the fact that a master NACK ends the requests. Directed cases add a Start in the middle of a byte, a Stop in the middle of a byte, and power failure both during a transfer and together with a Start, which separates a real re-arm from a leftover partial state.

// File: rtl/dib_pkg.sv
package dib_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a Start
    ST_ADDR,   // shifting the address byte
    ST_AACK,   // driving ACK for the address
    ST_WBYTE,  // shifting a write byte
    ST_WACK,   // driving ACK for a write byte
    ST_RLOAD,  // taking the requested read byte
    ST_RBYTE,  // driving read bits
    ST_RACK    // listening to the master's ACK
  } link_state_t;
endpackage

// File: rtl/dib_line_sync.sv
module dib_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  generate
    for (genvar l = 0; l < 2; l++) begin : g_line
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], raw[l]};
      end
      assign synced[l] = ff[STAGES-1];
    end
  endgenerate

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/dib_id_match.sv
module dib_id_match #(
  parameter int NUM_TGT = 2,
  parameter int ID_W    = 4,
  parameter logic [NUM_TGT*ID_W-1:0] IDS = {4'b1101, 4'b1010},
  localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic [ID_W-1:0]  id_field,
  output logic             id_hit,
  output logic [IDX_W-1:0] id_idx
);
  logic [NUM_TGT-1:0] eq;

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_cmp
      assign eq[t] = (id_field == IDS[t*ID_W +: ID_W]);
    end
  endgenerate

  always_comb begin
    id_hit = |eq;
    id_idx = '0;
    for (int t = NUM_TGT - 1; t >= 0; t--) begin
      if (eq[t]) id_idx = IDX_W'(t);
    end
  end
endmodule

// File: rtl/dib_link_fsm.sv
module dib_link_fsm
  import dib_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 4,
  parameter int SEL_W  = 3,
  parameter int IDX_W  = 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              pwr_fail,
  input  logic              id_hit,
  input  logic [IDX_W-1:0]  id_idx,
  input  logic              wr_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ID_W-1:0]   id_field,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [SEL_W-1:0]  sel,
  output logic              wr_fire,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_fire,
  output logic              sda_pull
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(DATA_W - 1);

  link_state_t       st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              rw, mack;
  logic              quiet;

  assign id_field = sh[DATA_W-1 -: ID_W];
  assign wr_data  = sh;
  assign quiet    = !pwr_fail && !start_det && !stop_det;

  assign wr_fire = quiet && (st == ST_WBYTE) && scl_fall && (cnt == LAST_BIT) && wr_ready;
  assign rd_fire = quiet && scl_fall &&
                   (((st == ST_AACK) && rw) || ((st == ST_RACK) && mack));

  always_comb begin
    case (st)
      ST_AACK, ST_WACK: sda_pull = 1'b1;
      ST_RBYTE:         sda_pull = ~sh[DATA_W-1];
      default:          sda_pull = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      tgt_idx <= '0;
      sel     <= '0;
    end else if (pwr_fail) begin
      st <= ST_IDLE;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise && cnt != LAST_BIT) begin
            sh  <= {sh[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_BIT) begin
            if (id_hit) begin
              st      <= ST_AACK;
              tgt_idx <= id_idx;
              sel     <= sh[SEL_W:1];
              rw      <= sh[0];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            st  <= rw ? ST_RLOAD : ST_WBYTE;
            cnt <= '0;
          end
        end
        ST_WBYTE: begin
          if (scl_rise && cnt != LAST_BIT) begin
            sh  <= {sh[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_BIT) begin
            st <= wr_ready ? ST_WACK : ST_IDLE;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st  <= ST_WBYTE;
            cnt <= '0;
          end
        end
        ST_RLOAD: begin
          sh  <= rd_data;
          cnt <= '0;
          st  <= ST_RBYTE;
        end
        ST_RBYTE: begin
          if (scl_fall) begin
            if (cnt == LAST_OUT) begin
              st   <= ST_RACK;
              mack <= 1'b0;
            end else begin
              sh  <= {sh[DATA_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) st <= mack ? ST_RLOAD : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a Start outside power failure re-arms address reception
  assert_start_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !pwr_fail) |=> (st == ST_ADDR && !sda_pull));

  // R4: a Stop leaves the link idle with SDA released
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !pwr_fail && !start_det) |=> (st == ST_IDLE && !sda_pull));

  // R7: a read request is always followed by the load of the byte
  assert_read_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (st == ST_RLOAD));

  // R9: the pull only changes while SCL is low, power failure aside
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(pwr_fail)) |-> !scl_s);
endmodule

// File: rtl/dual_id_bus_slave.sv
module dual_id_bus_slave #(
  parameter int          DATA_W  = 8,
  parameter int          ID_W    = 4,
  parameter int          SEL_W   = 3,
  parameter int          SYNC_FF = 2,
  parameter logic [ID_W-1:0] MEM_ID = 4'b1010,
  parameter logic [ID_W-1:0] RTC_ID = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              pwr_fail_i,
  output logic [SEL_W-1:0]  dev_sel_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic              mem_rd_req_o,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              rtc_wr_valid_o,
  input  logic              rtc_wr_ready_i,
  output logic              rtc_rd_req_o,
  input  logic [DATA_W-1:0] rtc_rd_data_i
);
  localparam int NUM_TGT = 2;
  localparam int IDX_W   = 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic id_hit, wr_fire, rd_fire;
  logic [IDX_W-1:0]  id_idx, tgt_idx;
  logic [ID_W-1:0]   id_field;
  logic [NUM_TGT-1:0] t_ready, t_valid, t_req;
  logic [DATA_W-1:0] t_rdata [NUM_TGT];

  assign t_ready    = {rtc_wr_ready_i, mem_wr_ready_i};
  assign t_rdata[0] = mem_rd_data_i;
  assign t_rdata[1] = rtc_rd_data_i;

  dib_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dib_id_match #(.NUM_TGT(NUM_TGT), .ID_W(ID_W), .IDS({RTC_ID, MEM_ID})) u_match (
    .id_field(id_field), .id_hit(id_hit), .id_idx(id_idx)
  );

  dib_link_fsm #(.DATA_W(DATA_W), .ID_W(ID_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .pwr_fail(pwr_fail_i),
    .id_hit(id_hit), .id_idx(id_idx),
    .wr_ready(t_ready[tgt_idx]), .rd_data(t_rdata[tgt_idx]),
    .id_field(id_field), .tgt_idx(tgt_idx), .sel(dev_sel_o),
    .wr_fire(wr_fire), .wr_data(wr_data_o), .rd_fire(rd_fire),
    .sda_pull(sda_pull_o)
  );

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_steer
      assign t_valid[t] = wr_fire && (tgt_idx == IDX_W'(t));
      assign t_req[t]   = rd_fire && (tgt_idx == IDX_W'(t));
    end
  endgenerate

  assign mem_wr_valid_o = t_valid[0];
  assign rtc_wr_valid_o = t_valid[1];
  assign mem_rd_req_o   = t_req[0];
  assign rtc_rd_req_o   = t_req[1];

  // R2: at most one strobe on at most one back end per cycle
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t_valid, t_req}));

  // R6: a write is only offered to a port that is ready
  assert_mem_valid_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid_o |-> mem_wr_ready_i);
  assert_rtc_valid_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_wr_valid_o |-> rtc_wr_ready_i);

  // R7: read requests are single-cycle strobes
  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req_o || rtc_rd_req_o) |=> !(mem_rd_req_o || rtc_rd_req_o));

  // R8: a power failure releases the bus on the next cycle
  assert_pwrfail_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (!sda_pull_o && !mem_wr_valid_o && !rtc_wr_valid_o));
endmodule

// File: tb/dual_id_bus_slave_test.sv
module dual_id_bus_slave_test;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  logic mem_rdy = 1'b1, rtc_rdy = 1'b1;
  logic sda_pull, sda_line;
  logic [2:0] dev_sel;
  logic [7:0] wr_data, mem_rdata, rtc_rdata;
  logic mem_wv, mem_rq, rtc_wv, rtc_rq;
  int n_chk = 0, n_err = 0;
  int mem_wn = 0, rtc_wn = 0, mem_rn = 0, rtc_rn = 0;
  logic [7:0] mem_last = 8'h00, rtc_last = 8'h00;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  dual_id_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .pwr_fail_i(pwr_fail), .dev_sel_o(dev_sel),
    .wr_data_o(wr_data),
    .mem_wr_valid_o(mem_wv), .mem_wr_ready_i(mem_rdy),
    .mem_rd_req_o(mem_rq), .mem_rd_data_i(mem_rdata),
    .rtc_wr_valid_o(rtc_wv), .rtc_wr_ready_i(rtc_rdy),
    .rtc_rd_req_o(rtc_rq), .rtc_rd_data_i(rtc_rdata)
  );

  // back-end models: count writes, answer reads one cycle after request
  always @(posedge clk) begin
    if (mem_wv) begin mem_wn <= mem_wn + 1; mem_last <= wr_data; end
    if (rtc_wv) begin rtc_wn <= rtc_wn + 1; rtc_last <= wr_data; end
    if (mem_rq) begin mem_rn <= mem_rn + 1; mem_rdata <= 8'h40 + 8'(mem_rn); end
    if (rtc_rq) begin rtc_rn <= rtc_rn + 1; rtc_rdata <= 8'h90 + 8'(rtc_rn); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    scl_m = 1'b0; wt(2); sda_m = b; wt(H - 2);
    scl_m = 1'b1; wt(H);
  endtask

  task automatic get_bit(output logic b);
    scl_m = 1'b0; wt(2); sda_m = 1'b1; wt(H - 2);
    scl_m = 1'b1; wt(H / 2); b = sda_line; wt(H / 2);
  endtask

  task automatic gen_start();
    scl_m = 1'b0; wt(2); sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H);
  endtask

  task automatic gen_stop();
    scl_m = 1'b0; wt(2); sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic get_ack(output logic a);
    logic b;
    get_bit(b);
    a = !b;
  endtask

  task automatic read_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    send_bit(!ack);
  endtask

  // {addr, data, ready, exp addr ack, exp data ack, target(0 mem,1 rtc,3 none)}
  localparam logic [20:0] VEC [8] = '{
    {8'hA6, 8'h5A, 1'b1, 1'b1, 1'b1, 2'd0},
    {8'hD2, 8'hC3, 1'b1, 1'b1, 1'b1, 2'd1},
    {8'hB0, 8'h11, 1'b1, 1'b0, 1'b0, 2'd3},
    {8'hA0, 8'h77, 1'b0, 1'b1, 1'b0, 2'd3},
    {8'hDE, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1},
    {8'h50, 8'h22, 1'b1, 1'b0, 1'b0, 2'd3},
    {8'hDA, 8'hFF, 1'b0, 1'b1, 1'b0, 2'd3},
    {8'hAE, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic a, d;
    logic [7:0] rb;
    int m0, r0;
    wt(5);
    chk("R8 reset pull", int'(sda_pull), 0);
    rst_n = 1'b1;
    wt(5);
    chk("R2 reset strobes", int'({mem_wv, mem_rq, rtc_wv, rtc_rq}), 0);

    // table walk: R1 R2 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic [7:0] ad, dt;
      ad = VEC[v][20:13]; dt = VEC[v][12:5];
      mem_rdy = VEC[v][4]; rtc_rdy = VEC[v][4];
      m0 = mem_wn; r0 = rtc_wn;
      gen_start(); send_byte(ad); get_ack(a); d = 1'b0;
      if (a) begin send_byte(dt); get_ack(d); end
      gen_stop(); wt(4);
      chk($sformatf("R1/R2 addr ack vec%0d", v), int'(a), int'(VEC[v][3]));
      chk($sformatf("R6 data ack vec%0d", v), int'(d), int'(VEC[v][2]));
      chk($sformatf("R1 mem writes vec%0d", v), mem_wn - m0, (VEC[v][1:0] == 2'd0) ? 1 : 0);
      chk($sformatf("R2 rtc writes vec%0d", v), rtc_wn - r0, (VEC[v][1:0] == 2'd1) ? 1 : 0);
      if (VEC[v][1:0] == 2'd0) chk("R1 mem byte", int'(mem_last), int'(dt));
      if (VEC[v][1:0] == 2'd1) chk("R2 rtc byte", int'(rtc_last), int'(dt));
      if (VEC[v][1:0] != 2'd3) chk("R5 select bits", int'(dev_sel), int'(ad[3:1]));
    end
    mem_rdy = 1'b1; rtc_rdy = 1'b1;

    // R7: memory read of three bytes, last one NACKed
    gen_start(); send_byte(8'hA3); get_ack(a);
    chk("R7 read addr ack", int'(a), 1);
    read_byte(rb, 1'b1); chk("R7 mem byte0", int'(rb), 'h40);
    read_byte(rb, 1'b1); chk("R7 mem byte1", int'(rb), 'h41);
    read_byte(rb, 1'b0); chk("R7 mem byte2", int'(rb), 'h42);
    scl_m = 1'b0; wt(H);
    chk("R7 released after NACK", int'(sda_pull), 0);
    gen_stop(); wt(4);
    chk("R7 mem request count", mem_rn, 3);
    chk("R5 read select", int'(dev_sel), 1);

    // R7: companion read of two bytes
    gen_start(); send_byte(8'hD1); get_ack(a);
    read_byte(rb, 1'b1); chk("R7 rtc byte0", int'(rb), 'h90);
    read_byte(rb, 1'b0); chk("R7 rtc byte1", int'(rb), 'h91);
    gen_stop(); wt(4);
    chk("R7 rtc request count", rtc_rn, 2);
    chk("R2 no mem request on rtc read", mem_rn, 3);

    // R3: repeated Start in the middle of a data byte
    m0 = mem_wn; r0 = rtc_wn;
    gen_start(); send_byte(8'hA0); get_ack(a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    gen_start(); send_byte(8'hD4); get_ack(a);
    chk("R3 ack after restart", int'(a), 1);
    send_byte(8'h3C); get_ack(d); gen_stop(); wt(4);
    chk("R3 partial byte dropped", mem_wn - m0, 0);
    chk("R3 new write landed", rtc_wn - r0, 1);
    chk("R3 new write byte", int'(rtc_last), 'h3C);

    // R3: Start in the middle of the address byte
    gen_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    gen_start(); send_byte(8'hA8); get_ack(a); gen_stop(); wt(4);
    chk("R3 address restart ack", int'(a), 1);
    chk("R5 address restart select", int'(dev_sel), 4);

    // R4: Stop in the middle of a data byte
    m0 = mem_wn;
    gen_start(); send_byte(8'hA0); get_ack(a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    gen_stop(); wt(4);
    chk("R4 no write after stop", mem_wn - m0, 0);
    chk("R4 pull released", int'(sda_pull), 0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    get_ack(d);
    chk("R4 trailing bits not acked", int'(d), 0);
    gen_stop(); wt(4);
    chk("R4 still no write", mem_wn - m0, 0);

    // R8: power failure during a write
    m0 = mem_wn;
    gen_start(); send_byte(8'hA0); get_ack(a);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    pwr_fail = 1'b1; wt(6); pwr_fail = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    get_ack(d);
    chk("R8 no ack after power fail", int'(d), 0);
    gen_stop(); wt(4);
    chk("R8 write discarded", mem_wn - m0, 0);

    // R8: Start seen during power failure is ignored
    pwr_fail = 1'b1; gen_start(); pwr_fail = 1'b0;
    send_byte(8'hA0); get_ack(a);
    chk("R8 start during fail ignored", int'(a), 0);
    gen_stop(); wt(4);
    gen_start(); send_byte(8'hA0); get_ack(a);
    send_byte(8'h99); get_ack(d); gen_stop(); wt(4);
    chk("R8 fresh start accepted", int'(a), 1);
    chk("R8 write after recovery", int'(mem_last), 'h99);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule